// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date as packed BCD fields. A free-running clock-enable input, pulsing at the 32.768 kHz oscillator rate, is divided down to one update per second. On each update the block advances seconds, minutes and hours. It then carries into the day of week, the day of month, the month and the year. When the year wraps, a century bit flips. Month lengths and leap-year Februaries are handled inside the block.

Software reaches the fields through a simple indexed port. A write sets one field on the next clock edge. The read port is combinational and always shows the live register values. The hours field works in two modes: a 24-hour count, or a 12-hour count with a PM bit. A one-cycle strobe marks each once-per-second update, so that neighbouring logic such as alarm comparators can sample the new time exactly once.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, day of month 0x01, month 0x01 with century 0 and year 0x00.
- R2: Field index 0 is seconds [6:0], 1 is minutes [6:0], 2 is hours, 3 is weekday [2:0], 4 is day of month [5:0], 5 is month [4:0] with the century bit at [7], and 6 is year [7:0]. Undefined bits read 0. Index 7 reads 0x00, and a write to index 7 changes no field.
- R3: Seconds and minutes count in BCD from 00 to 59. On the update that leaves 59, the field goes to 00 and carries into the next field.
- R4: In 24-hour mode (hours bit 6 = 0), hours bits [5:0] count in BCD from 00 to 23. The update that leaves 23:59:59 sets the time to 00:00:00 and advances the date.
- R5: In 12-hour mode (hours bit 6 = 1), bits [4:0] count 01 to 12 and bit 5 is PM. The order is 11, then 12, then 01. PM flips on the step from 11 to 12. Only the step from 11 PM to 12 AM advances the date.
- R6: The weekday counts 1 to 7 and goes back to 1 when the date advances from 7.
- R7: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. A month wrap takes the month from 12 back to 01 and carries into the year.
- R8: February ends at 29 when the year, read as a decimal number, is divisible by 4 (00 included). Otherwise it ends at 28.
- R9: The year counts in BCD from 00 to 99. The wrap from 99 to 00 flips the century bit.
- R10: One update happens for every TICKS_PER_SEC cycles in which both osc_en and tick_en are high. While osc_en is low, nothing advances and no strobe is emitted.
- R11: A write to the seconds field clears the sub-second divider. The next update then comes after a full TICKS_PER_SEC enabled cycles.
- R12: sec_tick is high for exactly one cycle per update. That cycle is the first one in which the read port shows the updated fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Global run enable; low halts the divider |
| tick_en | input | 1 | Oscillator-rate clock enable |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field index for writes |
| wr_data | input | 8 | Write data in packed BCD |
| rd_addr | input | 3 | Field index for reads |
| rd_data | output | 8 | Live value of the selected field |
| sec_tick | output | 1 | One-cycle once-per-second update strobe |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4, so one simulated second takes four enabled cycles. At that rate, every carry chain can be reached within a few cycles of preloading the fields: minute, hour, day, month, leap February and century. The small divider also makes it cheap to stop the divider part-way through a second, rewrite the seconds field, and count the exact number of enabled cycles until the next update.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FIELD_IDX_W = 3;

    typedef enum logic [FIELD_IDX_W-1:0] {
        IDX_SEC  = 3'd0,
        IDX_MIN  = 3'd1,
        IDX_HOUR = 3'd2,
        IDX_WDAY = 3'd3,
        IDX_MDAY = 3'd4,
        IDX_MON  = 3'd5,
        IDX_YEAR = 3'd6,
        IDX_NONE = 3'd7
    } fld_idx_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic       mode12;
        logic       hbit5;
        logic [4:0] hr;
    } tod_t;

    typedef struct packed {
        logic [2:0] wday;
        logic [5:0] mday;
        logic       cent;
        logic [4:0] mon;
        logic [7:0] year;
    } cal_t;

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // decimal value divisible by 4: (2*tens + ones) mod 4 == 0
    function automatic logic is_leap(input logic [7:0] yr);
        logic [1:0] s;
        s = yr[1:0] + {yr[4], 1'b0};
        return (s == 2'b00);
    endfunction

    function automatic logic [5:0] month_last_day(input logic [4:0] mon, input logic [7:0] yr);
        case (mon)
            5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic roll
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt;

    assign roll = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt <= '0;
        else if (roll)       cnt <= '0;
        else if (run)        cnt <= cnt + 1'b1;
    end

    assert_cnt_range_R10: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_clr_restart_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rtc_tod_chain.sv
module rtc_tod_chain
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       wr_en,
    input  fld_idx_e   wr_idx,
    input  logic [6:0] wr_data,
    output tod_t       tod,
    output logic       day_carry
);
    tod_t       nxt;
    logic [5:0] h24;

    always_comb begin
        nxt       = tod;
        day_carry = 1'b0;
        h24       = {tod.hbit5, tod.hr};
        if (adv) begin
            if (tod.sec == 7'h59) begin
                nxt.sec = 7'h00;
                if (tod.min == 7'h59) begin
                    nxt.min = 7'h00;
                    if (tod.mode12) begin
                        if (tod.hr == 5'h12) begin
                            nxt.hr = 5'h01;
                        end else if (tod.hr == 5'h11) begin
                            nxt.hr    = 5'h12;
                            nxt.hbit5 = ~tod.hbit5;
                            day_carry = tod.hbit5;
                        end else begin
                            nxt.hr = 5'(bcd_inc8({3'b000, tod.hr}));
                        end
                    end else begin
                        if (h24 == 6'h23) begin
                            {nxt.hbit5, nxt.hr} = 6'h00;
                            day_carry = 1'b1;
                        end else begin
                            {nxt.hbit5, nxt.hr} = 6'(bcd_inc8({2'b00, h24}));
                        end
                    end
                end else begin
                    nxt.min = 7'(bcd_inc8({1'b0, tod.min}));
                end
            end else begin
                nxt.sec = 7'(bcd_inc8({1'b0, tod.sec}));
            end
        end
        if (wr_en) begin
            case (wr_idx)
                IDX_SEC:  nxt.sec = wr_data;
                IDX_MIN:  nxt.min = wr_data;
                IDX_HOUR: begin
                    nxt.mode12 = wr_data[6];
                    nxt.hbit5  = wr_data[5];
                    nxt.hr     = wr_data[4:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tod <= '0;
        else     tod <= nxt;
    end

    assert_sec_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv && !(wr_en && wr_idx == IDX_SEC)) |=> $stable(tod.sec));

    assert_min_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_en && tod.sec == 7'h59 && tod.min == 7'h59) |=> (tod.min == 7'h00));

    assert_pm_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_en && tod.mode12 && tod.hr == 5'h11 && tod.min == 7'h59 && tod.sec == 7'h59)
        |=> (tod.hbit5 != $past(tod.hbit5)));

endmodule

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       wr_en,
    input  fld_idx_e   wr_idx,
    input  logic [7:0] wr_data,
    output cal_t       cal
);
    cal_t       nxt;
    logic [5:0] last_day;

    assign last_day = month_last_day(cal.mon, cal.year);

    always_comb begin
        nxt = cal;
        if (adv) begin
            nxt.wday = (cal.wday == 3'd7) ? 3'd1 : cal.wday + 3'd1;
            if (cal.mday == last_day) begin
                nxt.mday = 6'h01;
                if (cal.mon == 5'h12) begin
                    nxt.mon = 5'h01;
                    if (cal.year == 8'h99) begin
                        nxt.year = 8'h00;
                        nxt.cent = ~cal.cent;
                    end else begin
                        nxt.year = bcd_inc8(cal.year);
                    end
                end else begin
                    nxt.mon = 5'(bcd_inc8({3'b000, cal.mon}));
                end
            end else begin
                nxt.mday = 6'(bcd_inc8({2'b00, cal.mday}));
            end
        end
        if (wr_en) begin
            case (wr_idx)
                IDX_WDAY: nxt.wday = wr_data[2:0];
                IDX_MDAY: nxt.mday = wr_data[5:0];
                IDX_MON: begin
                    nxt.cent = wr_data[7];
                    nxt.mon  = wr_data[4:0];
                end
                IDX_YEAR: nxt.year = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal.wday <= 3'd1;
            cal.mday <= 6'h01;
            cal.cent <= 1'b0;
            cal.mon  <= 5'h01;
            cal.year <= 8'h00;
        end else begin
            cal <= nxt;
        end
    end

    assert_mday_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_en && cal.mday == last_day) |=> (cal.mday == 6'h01));

    assert_cent_flip_R9: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_en && cal.mday == last_day && cal.mon == 5'h12 && cal.year == 8'h99)
        |=> (cal.cent != $past(cal.cent)));

    assert_wday_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_en && cal.wday == 3'd7) |=> (cal.wday == 3'd1));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_en,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       sec_tick
);
    fld_idx_e wr_idx;
    logic     wr_sec;
    logic     roll;
    logic     adv;
    logic     day_carry;
    tod_t     tod;
    cal_t     cal;

    assign wr_idx = fld_idx_e'(wr_addr);
    assign wr_sec = wr_en && (wr_idx == IDX_SEC);
    assign adv    = roll && !wr_sec;

    rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (osc_en && tick_en),
        .clr  (wr_sec),
        .roll (roll)
    );

    rtc_tod_chain u_tod (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data[6:0]),
        .tod       (tod),
        .day_carry (day_carry)
    );

    rtc_cal_chain u_cal (
        .clk     (clk),
        .rst     (rst),
        .adv     (day_carry),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cal     (cal)
    );

    always_ff @(posedge clk) begin
        if (rst) sec_tick <= 1'b0;
        else     sec_tick <= adv;
    end

    always_comb begin
        case (fld_idx_e'(rd_addr))
            IDX_SEC:  rd_data = {1'b0, tod.sec};
            IDX_MIN:  rd_data = {1'b0, tod.min};
            IDX_HOUR: rd_data = {1'b0, tod.mode12, tod.hbit5, tod.hr};
            IDX_WDAY: rd_data = {5'b0, cal.wday};
            IDX_MDAY: rd_data = {2'b0, cal.mday};
            IDX_MON:  rd_data = {cal.cent, 2'b0, cal.mon};
            IDX_YEAR: rd_data = cal.year;
            default:  rd_data = 8'h00;
        endcase
    end

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> !sec_tick);

    // holds for TICKS_PER_SEC >= 2
    assert_tick_single_R12: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       sec_tick;

    int total = 0;
    int bad = 0;
    int ticks_seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] a;
        logic [7:0] e;
        string      tag;
    } item_t;
    item_t q[$];
    item_t it;

    always #2 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick)
    );

    // monitor: counts strobes and scores queued read expectations
    always @(negedge clk) begin
        if (sec_tick) ticks_seen++;
        if (q.size() > 0) begin
            it = q.pop_front();
            total++;
            if (rd_data !== it.e) begin
                bad++;
                $display("FAIL %s idx=%0d actual=%h expected=%h", it.tag, it.a, rd_data, it.e);
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        rd_addr = a;
        q.push_back('{a, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run(input int k, input logic te);
        @(posedge clk); #1;
        osc_en = 1'b1; tick_en = te;
        repeat (k) @(posedge clk);
        #1;
        osc_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                           input logic [7:0] wd, input logic [7:0] md,
                           input logic [7:0] mo, input logic [7:0] yr);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, md); wr(3'd3, wd);
        wr(3'd2, h);  wr(3'd1, m);  wr(3'd0, s);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;

        // R1 reset state
        expect_reg(3'd0, 8'h00, "R1 sec");
        expect_reg(3'd1, 8'h00, "R1 min");
        expect_reg(3'd2, 8'h00, "R1 hour");
        expect_reg(3'd3, 8'h01, "R1 wday");
        expect_reg(3'd4, 8'h01, "R1 mday");
        expect_reg(3'd5, 8'h01, "R1 month");
        expect_reg(3'd6, 8'h00, "R1 year");

        // R2 masking and the unused index
        wr(3'd1, 8'hD9);
        expect_reg(3'd1, 8'h59, "R2 minute mask");
        wr(3'd3, 8'hFD);
        expect_reg(3'd3, 8'h05, "R2 weekday mask");
        wr(3'd7, 8'hAA);
        expect_reg(3'd7, 8'h00, "R2 idx7 reads zero");
        expect_reg(3'd0, 8'h00, "R2 idx7 write ignored sec");
        expect_reg(3'd1, 8'h59, "R2 idx7 write ignored min");

        // R3 and R12: two seconds from 00:00:58
        set_all(8'h00, 8'h00, 8'h58, 8'h01, 8'h01, 8'h01, 8'h00);
        ticks_seen = 0;
        run(2 * TPS, 1'b1);
        @(negedge clk); #1;
        chk(ticks_seen, 2, "R12 strobe count");
        expect_reg(3'd0, 8'h00, "R3 sec wrap");
        expect_reg(3'd1, 8'h01, "R3 min carry");

        // R11 seconds write clears divider
        wr(3'd0, 8'h10);
        run(2, 1'b1);
        wr(3'd0, 8'h20);
        run(TPS - 1, 1'b1);
        expect_reg(3'd0, 8'h20, "R11 no early update");
        run(1, 1'b1);
        expect_reg(3'd0, 8'h21, "R11 full second");

        // R10 halting
        ticks_seen = 0;
        run(3 * TPS, 1'b0);
        expect_reg(3'd0, 8'h21, "R10 tick_en low holds");
        @(posedge clk); #1; tick_en = 1'b1;
        repeat (3 * TPS) @(posedge clk);
        #1 tick_en = 1'b0;
        @(negedge clk); #1;
        expect_reg(3'd0, 8'h21, "R10 osc_en low holds");
        chk(ticks_seen, 0, "R10 no strobe while halted");

        // R4, R6 midnight in 24-hour mode
        set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h03, 8'h21);
        run(TPS, 1'b1);
        expect_reg(3'd2, 8'h00, "R4 hour wrap");
        expect_reg(3'd1, 8'h00, "R4 min wrap");
        expect_reg(3'd4, 8'h16, "R4 date advance");
        expect_reg(3'd3, 8'h01, "R6 weekday wrap");

        // R5 12-hour mode
        set_all(8'h51, 8'h59, 8'h59, 8'h03, 8'h10, 8'h03, 8'h21);
        run(TPS, 1'b1);
        expect_reg(3'd2, 8'h72, "R5 11AM to 12PM");
        expect_reg(3'd3, 8'h03, "R5 noon no day carry");
        wr(3'd2, 8'h72); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        run(TPS, 1'b1);
        expect_reg(3'd2, 8'h61, "R5 12PM to 1PM");
        wr(3'd2, 8'h71); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        run(TPS, 1'b1);
        expect_reg(3'd2, 8'h52, "R5 11PM to 12AM");
        expect_reg(3'd3, 8'h04, "R5 midnight day carry");
        expect_reg(3'd4, 8'h11, "R5 midnight date carry");

        // R7 month lengths
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h21);
        run(TPS, 1'b1);
        expect_reg(3'd4, 8'h01, "R7 April 30 wraps");
        expect_reg(3'd5, 8'h05, "R7 to May");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h05, 8'h21);
        run(TPS, 1'b1);
        expect_reg(3'd4, 8'h31, "R7 May has 31");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h01, 8'h21);
        run(TPS, 1'b1);
        expect_reg(3'd5, 8'h02, "R7 Jan to Feb");

        // R8 February
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
        run(TPS, 1'b1);
        expect_reg(3'd5, 8'h03, "R8 year 23 Feb 28 ends");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
        run(TPS, 1'b1);
        expect_reg(3'd4, 8'h29, "R8 year 24 leap");
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        run(TPS, 1'b1);
        expect_reg(3'd5, 8'h03, "R8 leap Feb 29 ends");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h00);
        run(TPS, 1'b1);
        expect_reg(3'd4, 8'h29, "R8 year 00 leap");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h10);
        run(TPS, 1'b1);
        expect_reg(3'd4, 8'h01, "R8 year 10 not leap");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h12);
        run(TPS, 1'b1);
        expect_reg(3'd4, 8'h29, "R8 year 12 leap");

        // R9 year and century
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h99);
        run(TPS, 1'b1);
        expect_reg(3'd6, 8'h00, "R9 year wrap");
        expect_reg(3'd5, 8'h81, "R9 century set");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h92, 8'h99);
        run(TPS, 1'b1);
        expect_reg(3'd5, 8'h01, "R9 century clear");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h41);
        run(TPS, 1'b1);
        expect_reg(3'd6, 8'h42, "R9 year bcd inc");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule